// File: doc/BRIEF.md
# Bit-Sliced Four-Operation ALU

This block is a small combinational arithmetic and logic unit. It is built from a row of identical one-bit slices, and one ripple carry path runs through the whole row. A 2-bit operation select picks one of four operations on the operands: addition, subtraction, bitwise AND, or a one-place shift toward the most significant bit. The block returns a result word and a carry-out. It has no clock and no state, so the outputs depend only on the present inputs.

A small decoder turns the select into one-hot operation enables. It also produces an inverted add enable. Each slice merges its three candidate result bits through an AND-OR output stage.

Subtraction uses the same adder chain with the second operand inverted. The shift operation also reuses the carry path. Each slice hands its own operand-A bit to the next slice as carry, and each slice outputs the carry it receives as its result bit. The word therefore moves one place up. The external carry-in fills bit 0, and the original top bit of A leaves on the carry-out.

Top module: `alu4`

## Requirements
- R1: The select encoding is 00 = add, 01 = subtract, 10 = bitwise AND and 11 = shift left. The decoder raises exactly one operation enable for any known select value.
- R2: With select 00, {carry-out, result} equals A + B + carry-in, taken as a 5-bit unsigned sum.
- R3: With select 01, {carry-out, result} equals A + (bitwise NOT B, 4 bits) + carry-in. With carry-in = 1 the result is A − B modulo 16, and carry-out = 1 exactly when A ≥ B (no borrow).
- R4: With select 10, the result is A AND B and carry-out is 0, whatever the value of carry-in.
- R5: With select 11, the result is {A[2:0], carry-in} and carry-out is A[3]. The B operand has no effect on either output.
- R6: The outputs are a pure function of the present inputs. The same input vector gives the same outputs whatever inputs came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand (shifted operand in shift mode) |
| b_i | input | 4 | Second operand |
| carry_i | input | 1 | Carry-in; shift fill bit in shift mode |
| op_sel_i | input | 2 | Operation select (00 add, 01 sub, 10 AND, 11 shift) |
| result_o | output | 4 | Result word |
| carry_o | output | 1 | Carry-out; no-borrow flag in subtract; bit shifted out in shift |

## Verification
Whenever the inputs are known, the embedded assertions check the following:
- the decoder's enables are one-hot;
- each slice zeroes its carry in AND mode and passes carry to result in shift mode;
- the assembled word matches the 5-bit arithmetic sum in add and subtract modes.

Only the bench's sweep can show the cases the per-cycle checks do not cover:
- that B is ignored in shift mode;
- that carry-in is ignored in AND mode;
- the borrow meaning of carry-out across every operand pair;
- that outputs do not depend on earlier vectors.

The bench shows these by applying every select, operand and carry-in combination and, after that, re-applying vectors in reverse order.

// File: rtl/alu4_pkg.sv
// Package alu4_pkg
// Holds the operation codes and the decoded enable bundle shared by the
// decoder, the bit slices and the top level of the four-operation ALU.
// Assumes a 2-bit operation select.
package alu4_pkg;

    // Operation codes carried on the select input.
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_SHL = 2'b11
    } alu_op_e;

    // One-hot operation enables plus the inverted add enable.
    typedef struct packed {
        logic add;
        logic add_n;
        logic sub;
        logic land;
        logic shl;
    } alu_en_t;

endpackage

// File: rtl/alu_op_decoder.sv
// Module alu_op_decoder
// Turns the 2-bit operation select into one-hot enables for add, subtract,
// AND and shift, and drives an active-low copy of the add enable.
// Assumes the select is stable while the result is consumed (pure logic).
module alu_op_decoder
    import alu4_pkg::*;
(
    input  logic [1:0] op_sel_i,
    output alu_en_t    en_o
);

    // Decode the select into one enable per operation.
    always_comb begin
        en_o = '0;
        unique case (op_sel_i)
            OP_ADD:  en_o.add  = 1'b1;
            OP_SUB:  en_o.sub  = 1'b1;
            OP_AND:  en_o.land = 1'b1;
            default: en_o.shl  = 1'b1;
        endcase
        en_o.add_n = ~en_o.add;
    end

    // Checks: exactly one operation enable for a known select (R1).
    always_comb begin
        if (!$isunknown(op_sel_i)) begin
            p_onehot_enable_r1: assert ($countones({en_o.add, en_o.sub, en_o.land, en_o.shl}) == 1)
                else $error("decoder enables not one-hot");
            p_shift_code_r1: assert ((op_sel_i == 2'b11) == en_o.shl)
                else $error("shift enable does not match code 11");
        end
    end

endmodule

// File: rtl/alu_bit_slice.sv
// Module alu_bit_slice
// One bit of the ALU.
//  - Add/subtract: a full adder, with B inverted when subtract is enabled.
//  - AND: a single AND gate.
//  - Shift: the slice passes its A bit on as carry and takes the incoming
//    carry as its result bit.
// An AND-OR stage merges the candidate result bits.
// Assumes the enables are one-hot.
module alu_bit_slice
    import alu4_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    c_i,
    input  alu_en_t en_i,
    output logic    y_o,
    output logic    c_o
);

    logic arith_en;
    logic b_eff;
    logic sum;
    logic maj;

    // Full adder with conditional inversion of B for subtraction.
    always_comb begin
        arith_en = ~en_i.add_n | en_i.sub;
        b_eff    = b_i ^ en_i.sub;
        sum      = a_i ^ b_eff ^ c_i;
        maj      = (a_i & b_eff) | (a_i & c_i) | (b_eff & c_i);
    end

    // AND-OR merge of result and carry by operation enable.
    always_comb begin
        y_o = (arith_en & sum) | (en_i.shl & c_i) | (en_i.land & a_i & b_i);
        c_o = (arith_en & maj) | (en_i.shl & a_i);
    end

    // Checks on the slice outputs (R4, R5).
    always_comb begin
        if (!$isunknown({a_i, b_i, c_i, en_i})) begin
            p_and_no_carry_r4: assert (!(en_i.land && c_o))
                else $error("carry raised in AND mode");
            p_shift_passes_carry_r5: assert (!en_i.shl || (y_o == c_i && c_o == a_i))
                else $error("shift slice does not move bits");
        end
    end

endmodule

// File: rtl/alu4.sv
// Module alu4
// Top of the four-operation ALU. One decoder feeds WIDTH identical bit
// slices that share a ripple carry path. The external carry-in enters
// slice 0, and the carry of the top slice leaves as carry_o.
// Assumes a purely combinational context: there is no clock and no state.
module alu4
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    input  logic [1:0]       op_sel_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);

    localparam int CHAIN = WIDTH + 1;

    alu_en_t          en;
    logic [CHAIN-1:0] chain;

    alu_op_decoder u_dec (
        .op_sel_i (op_sel_i),
        .en_o     (en)
    );

    // Feed the external carry into the bottom of the chain.
    always_comb chain[0] = carry_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_i  (a_i[i]),
            .b_i  (b_i[i]),
            .c_i  (chain[i]),
            .en_i (en),
            .y_o  (result_o[i]),
            .c_o  (chain[i+1])
        );
    end

    // Take the carry-out from the top of the chain.
    always_comb carry_o = chain[WIDTH];

    // Word-level arithmetic checks against 5-bit sums (R2, R3).
    logic [WIDTH:0] ref_add;
    logic [WIDTH:0] ref_sub;
    always_comb begin
        ref_add = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
        ref_sub = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, carry_i};
        if (!$isunknown({a_i, b_i, carry_i, op_sel_i})) begin
            if (op_sel_i == OP_ADD) begin
                p_add_sum_r2: assert ({carry_o, result_o} == ref_add)
                    else $error("add result mismatch");
            end
            if (op_sel_i == OP_SUB) begin
                p_sub_diff_r3: assert ({carry_o, result_o} == ref_sub)
                    else $error("subtract result mismatch");
            end
        end
    end

endmodule

// File: tb/tb_alu4.sv
// Bench tb_alu4
// Applies every combination of select, operands and carry-in to the
// combinational ALU and compares the outputs with values computed here.
// It then replays the vectors in reverse order to check that the outputs
// do not depend on history.
module tb_alu4;

    localparam int  W         = 4;
    localparam time HALF      = 10ns;
    localparam int  MAX_CYCLE = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b, y;
    logic         cin, cout;
    logic [1:0]   sel;
    int           checks = 0;
    int           fails  = 0;
    bit           done   = 1'b0;

    // 50 MHz clock.
    always #HALF clk = ~clk;

    alu4 #(.WIDTH(W)) dut (
        .a_i      (a),
        .b_i      (b),
        .carry_i  (cin),
        .op_sel_i (sel),
        .result_o (y),
        .carry_o  (cout)
    );

    // Compute the expected 5-bit {carry, result} from the requirements.
    function automatic logic [W:0] expect_of(input logic [1:0] s, input logic [W-1:0] x,
                                             input logic [W-1:0] z, input logic c);
        int v;
        case (s)
            2'b00:   v = int'(x) + int'(z) + int'(c);         // R2
            2'b01:   v = int'(x) + (15 - int'(z)) + int'(c);  // R3
            2'b10:   v = int'(x & z);                         // R4
            default: v = (int'(x) * 2 + int'(c)) % 32;       // R5: {A, cin}
        endcase
        return v[W:0];
    endfunction

    // Return the requirement tag for an operation code.
    function automatic string tag_of(input logic [1:0] s);
        case (s)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Compare one observed output with its expected value.
    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s sel=%b a=%h b=%h cin=%b actual=%h expected=%h",
                     req, sel, a, b, cin, act, exp_v);
        end
    endtask

    // Drive one vector at a rising edge and sample at the falling edge.
    task automatic apply(input logic [1:0] s, input logic [W-1:0] x,
                         input logic [W-1:0] z, input logic c, input string req);
        @(posedge clk);
        sel = s; a = x; b = z; cin = c;
        @(negedge clk);
        check(req, {cout, y}, expect_of(s, x, z, c));
    endtask

    // Main sequence: reset state, exhaustive sweep, then the reverse replay.
    initial begin
        sel = 2'b00; a = '0; b = '0; cin = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset-state", {cout, y}, '0);
        // Exhaustive forward sweep, covering R1 through every select code.
        for (int s = 0; s < 4; s++)
            for (int x = 0; x < 16; x++)
                for (int z = 0; z < 16; z++)
                    for (int c = 0; c < 2; c++)
                        apply(2'(s), 4'(x), 4'(z), 1'(c), {"R1 ", tag_of(2'(s))});
        // Borrow corners for R3: equal operands and A one below B.
        apply(2'b01, 4'h7, 4'h7, 1'b1, "R3 no-borrow");
        apply(2'b01, 4'h6, 4'h7, 1'b1, "R3 borrow");
        // R4: carry-in toggled with the operands fixed.
        apply(2'b10, 4'hF, 4'hA, 1'b1, "R4 cin ignored");
        apply(2'b10, 4'hF, 4'hA, 1'b0, "R4 cin ignored");
        // R5: B toggled with A and carry-in fixed.
        apply(2'b11, 4'h9, 4'h0, 1'b1, "R5 b ignored");
        apply(2'b11, 4'h9, 4'hF, 1'b1, "R5 b ignored");
        // R6: reverse-order replay, so each vector follows a different history.
        for (int s = 3; s >= 0; s--)
            for (int x = 15; x >= 0; x -= 3)
                for (int z = 15; z >= 0; z -= 5)
                    for (int c = 1; c >= 0; c--)
                        apply(2'(s), 4'(x), 4'(z), 1'(c), "R6 history");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (MAX_CYCLE) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule